// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block protects an in-order pipeline from the single data hazard that operand forwarding cannot resolve: a load sitting in execute whose result is needed by the instruction directly behind it in decode. The loaded value only exists after the memory stage. The dependent instruction must therefore wait one cycle, and it then picks the value up from the memory/writeback forwarding path.

When the hazard is present, the controller drops the program-counter write enable and the fetch/decode latch enable, so the front end freezes. It also raises a bubble select that clears the control bits of the entry going into execute. The load itself carries on downstream. A thin harness holds the program counter, the fetch/decode word and the execute-stage control, destination and load flag, so the effect of the strobes can be seen at the ports. Instruction decode is outside the block: the surrounding logic supplies the decoded source, destination and control fields of the word currently in the fetch/decode latch.

Control bits are packed as a 4-bit field: bit 0 register write, bit 1 memory read (this marks a load), bit 2 memory write, bit 3 branch.

Top module: `lu_stall_unit`

## Requirements
- R1: `bubbleSel` is 1 when all of these hold: the execute-stage control has register write (bit 0) set, it has memory read (bit 1) set, its destination is nonzero, and that destination equals `idSrcA` or `idSrcB`.
- R2: An execute-stage instruction without memory read never raises `bubbleSel`, even if it writes a register that decode reads.
- R3: An execute-stage destination of register 0 never raises `bubbleSel`.
- R4: On a clock edge with `pcWrEn` low, `pc` keeps its value. Otherwise `pc` advances by 4.
- R5: On a clock edge with `ifIdWrEn` low, `ifIdWord` keeps its value. Otherwise it captures `fetchWord`.
- R6: After an edge with `bubbleSel` high, `exCtrl` is 0 and `exDest` is the decode destination. After any other edge, `exCtrl` equals `idCtrl`.
- R7: `pcWrEn` and `ifIdWrEn` are both the inverse of `bubbleSel`.
- R8: While `rst` is high, `bubbleSel` is 0 and both enables are 1. After a reset edge, `pc`, `ifIdWord`, `exCtrl` and `exDest` are 0.
- R9: A load immediately followed by a user of its result gives exactly one bubble cycle. A user that trails the load by two instructions gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchWord | input | 32 | Instruction word from fetch |
| idSrcA | input | 5 | First source register of the decode instruction |
| idSrcB | input | 5 | Second source register of the decode instruction |
| idDest | input | 5 | Destination register of the decode instruction |
| idCtrl | input | 4 | Decoded control bits of the decode instruction |
| pcWrEn | output | 1 | Program counter write enable |
| ifIdWrEn | output | 1 | Fetch/decode latch enable |
| bubbleSel | output | 1 | Clears control of the entry going into execute |
| pc | output | 32 | Program counter |
| ifIdWord | output | 32 | Fetch/decode latch contents |
| exCtrl | output | 4 | Control bits held in the execute stage |
| exDest | output | 5 | Destination register held in the execute stage |

## Verification
A wrong execute-stage control or destination shows up in the very next cycle as a missed or spurious `bubbleSel`, together with the matching enables. A missed stall shows one edge later as `pc` and `ifIdWord` moving when they should hold, and as nonzero control entering execute. A stuck stall shows as `pc` freezing for more than one cycle on a load-use pair, so counting bubble cycles across back-to-back sequences exposes it within two cycles.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int REG_AW  = 5;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 32;
  localparam int PC_STEP = 4;

  typedef struct packed {
    logic branch;
    logic memWrite;
    logic memRead;
    logic regWrite;
  } ctrl_t;

  typedef struct packed {
    logic hold;    // freeze pc and fetch/decode latch
    logic bubble;  // zero control entering execute
  } strobe_t;
endpackage

// File: rtl/lu_hazard_ctrl.sv
module lu_hazard_ctrl
  import lu_pkg::*;
#(
  parameter int RegAw  = REG_AW,
  parameter int NumSrc = 2
) (
  input  logic                           rst,
  input  ctrl_t                          exCtrl,
  input  logic [RegAw-1:0]               exDest,
  input  logic [NumSrc-1:0][RegAw-1:0]   idSrc,
  output strobe_t                        strobe
);
  logic [NumSrc-1:0] srcHit;
  logic loadWrites;
  logic hazard;

  assign loadWrites = exCtrl.regWrite && exCtrl.memRead && (exDest != '0);

  for (genvar s = 0; s < NumSrc; s++) begin : g_src
    assign srcHit[s] = (idSrc[s] == exDest);
  end

  assign hazard = loadWrites && (|srcHit);

  always_comb begin
    strobe.hold   = hazard && !rst;
    strobe.bubble = hazard && !rst;
  end
endmodule

// File: rtl/lu_front_dp.sv
module lu_front_dp
  import lu_pkg::*;
#(
  parameter int AddrW  = ADDR_W,
  parameter int WordW  = WORD_W,
  parameter int RegAw  = REG_AW,
  parameter int PcStep = PC_STEP
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [WordW-1:0]  fetchWord,
  input  logic [RegAw-1:0]  idDest,
  input  ctrl_t             idCtrl,
  output logic [AddrW-1:0]  pc,
  output logic [WordW-1:0]  ifIdWord,
  output ctrl_t             exCtrl,
  output logic [RegAw-1:0]  exDest
);
  localparam logic [AddrW-1:0] StepVal = AddrW'(PcStep);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      ifIdWord <= '0;
    end else if (!strobe.hold) begin
      pc       <= pc + StepVal;
      ifIdWord <= fetchWord;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exCtrl <= '0;
      exDest <= '0;
    end else begin
      exCtrl <= strobe.bubble ? ctrl_t'('0) : idCtrl;
      exDest <= idDest;
    end
  end
endmodule

// File: rtl/lu_stall_unit.sv
module lu_stall_unit
  import lu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   fetchWord,
  input  logic [REG_AW-1:0]   idSrcA,
  input  logic [REG_AW-1:0]   idSrcB,
  input  logic [REG_AW-1:0]   idDest,
  input  logic [3:0]          idCtrl,
  output logic                pcWrEn,
  output logic                ifIdWrEn,
  output logic                bubbleSel,
  output logic [ADDR_W-1:0]   pc,
  output logic [WORD_W-1:0]   ifIdWord,
  output logic [3:0]          exCtrl,
  output logic [REG_AW-1:0]   exDest
);
  strobe_t strobe;
  ctrl_t   exCtrlQ;

  lu_hazard_ctrl #(.RegAw(REG_AW), .NumSrc(2)) ctrl_i (
    .rst    (rst),
    .exCtrl (exCtrlQ),
    .exDest (exDest),
    .idSrc  ({idSrcB, idSrcA}),
    .strobe (strobe)
  );

  lu_front_dp #(.AddrW(ADDR_W), .WordW(WORD_W), .RegAw(REG_AW), .PcStep(PC_STEP)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .fetchWord (fetchWord),
    .idDest    (idDest),
    .idCtrl    (ctrl_t'(idCtrl)),
    .pc        (pc),
    .ifIdWord  (ifIdWord),
    .exCtrl    (exCtrlQ),
    .exDest    (exDest)
  );

  assign exCtrl    = exCtrlQ;
  assign pcWrEn    = !strobe.hold;
  assign ifIdWrEn  = !strobe.hold;
  assign bubbleSel = strobe.bubble;
endmodule

// File: rtl/lu_stall_unit_chk.sv
module lu_stall_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        pcWrEn,
  input logic        ifIdWrEn,
  input logic        bubbleSel,
  input logic [31:0] pc,
  input logic [31:0] ifIdWord,
  input logic [3:0]  exCtrl,
  input logic [4:0]  exDest,
  input logic [3:0]  idCtrl
);
  // R2
  no_nonload_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !exCtrl[1] |-> !bubbleSel);
  // R3
  no_zero_dest_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (exDest == 5'd0) |-> !bubbleSel);
  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pcWrEn |=> $stable(pc));
  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    pcWrEn |=> (pc == $past(pc) + 32'd4));
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ifIdWrEn |=> $stable(ifIdWord));
  // R6
  bubble_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bubbleSel |=> (exCtrl == 4'd0));
  // R6
  pass_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    !bubbleSel |=> (exCtrl == $past(idCtrl)));
  // R8
  reset_enables_chk: assert property (@(posedge clk)
    rst |-> (pcWrEn && ifIdWrEn && !bubbleSel));
  // R9
  single_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    bubbleSel |=> !bubbleSel);
endmodule

bind lu_stall_unit lu_stall_unit_chk chk_i (
  .clk(clk), .rst(rst), .pcWrEn(pcWrEn), .ifIdWrEn(ifIdWrEn),
  .bubbleSel(bubbleSel), .pc(pc), .ifIdWord(ifIdWord),
  .exCtrl(exCtrl), .exDest(exDest), .idCtrl(idCtrl)
);

// File: tb/lu_stall_unit_tb_top.sv
`timescale 1ns/1ps
module lu_stall_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchWord = '0;
  logic [4:0]  idSrcA = '0, idSrcB = '0, idDest = '0;
  logic [3:0]  idCtrl = '0;
  logic        pcWrEn, ifIdWrEn, bubbleSel;
  logic [31:0] pc, ifIdWord;
  logic [3:0]  exCtrl;
  logic [4:0]  exDest;

  int nChk = 0, nBad = 0;
  logic [31:0] mPc = '0, mWord = '0;
  logic [3:0]  mCtrl = '0;
  logic [4:0]  mDest = '0;
  logic        lastStall = 1'b0;
  int          bubbles = 0;

  always #10 clk = ~clk;

  lu_stall_unit dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic predStall(input logic [3:0] c, input logic [4:0] d,
                                     input logic [4:0] a, input logic [4:0] b);
    return c[0] && c[1] && (d != 5'd0) && ((d == a) || (d == b));
  endfunction

  // one cycle: check state, drive decode fields, check strobes, clock, update model
  task automatic step(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                      input logic [3:0] c, input logic [31:0] w, input string tag);
    logic s;
    check({tag, " R4 pc"}, pc, mPc);
    check({tag, " R5 latch"}, ifIdWord, mWord);
    check({tag, " R6 exCtrl"}, exCtrl, mCtrl);
    check({tag, " R6 exDest"}, exDest, mDest);
    idSrcA = a; idSrcB = b; idDest = d; idCtrl = c; fetchWord = w;
    #1;
    s = predStall(mCtrl, mDest, a, b);
    check({tag, " R1 bubble"}, bubbleSel, s);
    check({tag, " R7 pcWrEn"}, pcWrEn, !s);
    check({tag, " R7 ifIdWrEn"}, ifIdWrEn, !s);
    if (s) bubbles++;
    @(posedge clk);
    if (!s) begin mPc += 32'd4; mWord = w; end
    mCtrl = s ? 4'd0 : c;
    mDest = d;
    lastStall = s;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int seed;
    logic [4:0] ra, rb, rd;
    logic [3:0] rc;
    seed = 32'h1234;
    void'($urandom(seed));
    // reset: drive a would-be hazard pattern on decode
    idSrcA = 5'd3; idCtrl = 4'b0011; idDest = 5'd3;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 pcWrEn in reset", pcWrEn, 1'b1);
    check("R8 ifIdWrEn in reset", ifIdWrEn, 1'b1);
    check("R8 bubble in reset", bubbleSel, 1'b0);
    check("R8 pc", pc, 0);
    check("R8 word", ifIdWord, 0);
    check("R8 exCtrl", exCtrl, 0);
    check("R8 exDest", exDest, 0);
    rst = 1'b0;

    // R9 back-to-back load-use: exactly one bubble
    bubbles = 0;
    step(5'd1, 5'd2, 5'd5, 4'b0011, 32'hA0, "R9 load");
    step(5'd5, 5'd6, 5'd7, 4'b0001, 32'hA1, "R9 use");
    step(5'd5, 5'd6, 5'd7, 4'b0001, 32'hA1, "R9 use held");
    step(5'd8, 5'd9, 5'd10, 4'b0001, 32'hA2, "R9 next");
    check("R9 one bubble back-to-back", bubbles, 1);
    // R9 user two slots behind load: no bubble
    bubbles = 0;
    step(5'd1, 5'd2, 5'd12, 4'b0011, 32'hB0, "R9 load2");
    step(5'd3, 5'd4, 5'd13, 4'b0001, 32'hB1, "R9 gap");
    step(5'd12, 5'd12, 5'd14, 4'b0001, 32'hB2, "R9 late use");
    check("R9 no bubble at distance two", bubbles, 0);
    // R2 non-load producer matched by src B
    bubbles = 0;
    step(5'd1, 5'd2, 5'd9, 4'b0001, 32'hC0, "R2 alu");
    step(5'd0, 5'd9, 5'd4, 4'b0001, 32'hC1, "R2 use");
    check("R2 no bubble for alu producer", bubbles, 0);
    // R3 load to r0
    step(5'd1, 5'd2, 5'd0, 4'b0011, 32'hD0, "R3 load r0");
    step(5'd0, 5'd0, 5'd4, 4'b0001, 32'hD1, "R3 use r0");
    check("R3 no bubble for r0", bubbles, 0);
    // R1 load then use via src B, with store/branch bits cleared by bubble (R6)
    step(5'd1, 5'd2, 5'd17, 4'b0011, 32'hE0, "R1 load");
    step(5'd4, 5'd17, 5'd18, 4'b1101, 32'hE1, "R1 useB");
    step(5'd4, 5'd17, 5'd18, 4'b1101, 32'hE1, "R1 useB held");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      if (!lastStall) begin
        ra = 5'($urandom_range(0, 3));
        rb = 5'($urandom_range(0, 3));
        rd = 5'($urandom_range(0, 3));
        rc = 4'($urandom);
      end
      step(ra, rb, rd, rc, $urandom, "rand");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule